// File: doc/BRIEF.md
# Non-Blocking Cache Miss Tracker

This block keeps count of the cache misses a core has sent toward memory, so that the cache can go on serving hits while miss data is on its way. A primary table holds one entry per distinct line that is waiting for memory. Each entry raises one bus request. A secondary table holds later misses to a line that a primary entry already waits for. Those misses raise no further bus traffic and ride on the fill of their primary.

When a fill returns, the block reports the primary miss as complete. It then reports each secondary miss tied to that line, one per cycle, oldest first. Uncached loads take a primary entry, never merge, and complete as soon as the bus accepts them. The core is stalled only when the table a miss needs is full, or while a drain is in progress. A drain holds off new misses and reports done once both tables are empty.

Top module: `miss_tracker`

## Requirements
- R1: A cacheable miss whose line (address bits above OFS_W) matches no waiting primary entry takes the lowest free primary entry. It is then offered on the bus port with that slot and line. An offered request keeps its slot and line until bus_req_ready is high on a clock edge.
- R2: A cacheable miss whose line matches a primary entry that is offered or waiting for its fill goes to the secondary table. It raises no new bus request.
- R3: With all PRI_N primary entries busy, a valid miss that needs a new primary entry sees req_stall high in the same cycle.
- R4: With all SEC_N secondary entries busy, a valid miss that would merge sees req_stall high in the same cycle.
- R5: req_stall is low whenever req_valid is low, so hits proceed. A mergeable miss is accepted even while the primary table is full.
- R6: A miss with req_nc high never merges and is not merged into. It stays offered on the bus with bus_req_nc high until accepted. Its completion (done_sec low) appears one cycle after the accepting edge, with no fill.
- R7: fill_valid at a clock edge for a slot waiting for its fill makes done_valid pulse after the next edge, with that miss's id and done_sec low. Its secondary misses then complete on following cycles, one per cycle, in allocation order, with done_sec high.
- R8: fill_valid for a slot that is free or not yet accepted by the bus is ignored and produces no completion.
- R9: While drain_req is high every valid miss is stalled. drain_done is high exactly when drain_req is high and no entry of either table is valid.
- R10: A synchronous active-high rst empties both tables, withdraws any bus request and clears done_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss presented this cycle |
| req_addr | input | ADDR_W | Byte address of the miss |
| req_nc | input | 1 | Miss is an uncached load |
| req_id | input | ID_W | Core tag returned on completion |
| req_stall | output | 1 | Miss not accepted this cycle |
| bus_req_valid | output | 1 | Line fetch offered to the bus |
| bus_req_ready | input | 1 | Bus takes the offered fetch |
| bus_req_line | output | ADDR_W-OFS_W | Line address of the offered fetch |
| bus_req_slot | output | $clog2(PRI_N) | Primary slot the fill must name |
| bus_req_nc | output | 1 | Offered fetch is uncached |
| fill_valid | input | 1 | Fill for a slot has returned |
| fill_slot | input | $clog2(PRI_N) | Slot the fill belongs to |
| done_valid | output | 1 | A miss completes this cycle |
| done_id | output | ID_W | Tag of the completed miss |
| done_line | output | ADDR_W-OFS_W | Line of the completed miss |
| done_sec | output | 1 | Completed miss came from the secondary table |
| drain_req | input | 1 | Hold new misses and empty the tables |
| drain_done | output | 1 | Drain requested and both tables empty |

## Verification
The hardest state to reach from the ports is a full secondary table beside a full primary table, with the bus still holding back. Only there can an ignored fill, a held bus offer and both stall causes be seen together. The bench reaches it by keeping bus_req_ready low. It fills the primary table with four distinct lines and then sends four repeat misses to lines already waiting. It then probes a fifth distinct line, a fifth repeat and a fill aimed at a slot the bus has not accepted. The ordered replay of secondaries after a fill is reached with a scripted cycle-by-cycle vector table.

// File: rtl/mtrk_pkg.sv
package mtrk_pkg;

  // Life cycle of one primary slot.
  typedef enum logic [2:0] {
    PS_FREE   = 3'd0,  // unused
    PS_ISSUE  = 3'd1,  // offered to the bus, not yet accepted
    PS_WAIT   = 3'd2,  // accepted, waiting for the fill
    PS_FILLED = 3'd3,  // data back (or uncached accepted), completion owed
    PS_REPLAY = 3'd4   // own completion sent, children still replaying
  } pstate_e;

endpackage

// File: rtl/mtrk_first.sv
// Lowest-index set bit of a request vector.
module mtrk_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mtrk_oldest.sv
// Oldest candidate according to an age matrix: older[j][i] set means j came before i.
module mtrk_oldest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        cand,
  input  logic [N-1:0][N-1:0] older,
  output logic                any,
  output logic [IW-1:0]       idx
);

  logic [N-1:0] sel;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sel[i] = cand[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j] && older[j][i]) sel[i] = 1'b0;
      end
    end
    any = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mtrk_prim_table.sv
// Primary table: one slot per distinct outstanding line, owns the bus offer.
module mtrk_prim_table
  import mtrk_pkg::*;
#(
  parameter int N      = 4,
  parameter int LINE_W = 28,
  parameter int ID_W   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LINE_W-1:0]         lk_line,
  input  logic                      lk_nc,
  output logic                      lk_hit_any,
  output logic [IW-1:0]             lk_hit_idx,
  output logic                      free_any,
  input  logic                      alloc_en,
  input  logic [LINE_W-1:0]         alloc_line,
  input  logic [ID_W-1:0]           alloc_id,
  input  logic                      alloc_nc,
  output logic                      bus_valid,
  input  logic                      bus_ready,
  output logic [IW-1:0]             bus_slot,
  output logic [LINE_W-1:0]         bus_line,
  output logic                      bus_nc,
  input  logic                      fill_valid,
  input  logic [IW-1:0]             fill_slot,
  input  logic                      cmp_take,
  input  logic [IW-1:0]             cmp_slot,
  input  logic [N-1:0]              child_any,
  output logic [N-1:0]              filled_vec,
  output logic [N-1:0]              replay_vec,
  output logic [N-1:0]              busy_vec,
  output logic [N-1:0][LINE_W-1:0]  ent_line,
  output logic [N-1:0][ID_W-1:0]    ent_id
);

  pstate_e           st_q   [N];
  logic [LINE_W-1:0] line_q [N];
  logic [ID_W-1:0]   id_q   [N];
  logic [N-1:0]      nc_q;

  logic [N-1:0]  free_v, issue_v, hit_v;
  logic [IW-1:0] free_idx, issue_idx;
  logic          issue_any;
  logic          hold_q;
  logic [IW-1:0] hold_slot_q;
  logic          bus_fire;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      free_v[i]     = (st_q[i] == PS_FREE);
      issue_v[i]    = (st_q[i] == PS_ISSUE);
      filled_vec[i] = (st_q[i] == PS_FILLED);
      replay_vec[i] = (st_q[i] == PS_REPLAY);
      busy_vec[i]   = (st_q[i] != PS_FREE);
      hit_v[i]      = ((st_q[i] == PS_ISSUE) || (st_q[i] == PS_WAIT)) &&
                      !nc_q[i] && !lk_nc && (line_q[i] == lk_line);
      ent_line[i]   = line_q[i];
      ent_id[i]     = id_q[i];
    end
  end

  mtrk_first #(.N(N)) u_free (.vec(free_v),  .any(free_any),   .idx(free_idx));
  mtrk_first #(.N(N)) u_iss  (.vec(issue_v), .any(issue_any),  .idx(issue_idx));
  mtrk_first #(.N(N)) u_hit  (.vec(hit_v),   .any(lk_hit_any), .idx(lk_hit_idx));

  // An offer that was not taken stays on the same slot.
  assign bus_slot  = hold_q ? hold_slot_q : issue_idx;
  assign bus_valid = hold_q || issue_any;
  assign bus_line  = line_q[bus_slot];
  assign bus_nc    = nc_q[bus_slot];
  assign bus_fire  = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= 1'b0;
      hold_slot_q <= '0;
    end else begin
      hold_q      <= bus_valid && !bus_ready;
      hold_slot_q <= bus_slot;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        st_q[i] <= PS_FREE;
      end else begin
        unique case (st_q[i])
          PS_FREE:   if (alloc_en && free_idx == IW'(i)) st_q[i] <= PS_ISSUE;
          PS_ISSUE:  if (bus_fire && bus_slot == IW'(i))
                       st_q[i] <= nc_q[i] ? PS_FILLED : PS_WAIT;
          PS_WAIT:   if (fill_valid && fill_slot == IW'(i)) st_q[i] <= PS_FILLED;
          PS_FILLED: if (cmp_take && cmp_slot == IW'(i))
                       st_q[i] <= child_any[i] ? PS_REPLAY : PS_FREE;
          PS_REPLAY: if (!child_any[i]) st_q[i] <= PS_FREE;
          default:   st_q[i] <= PS_FREE;
        endcase
      end
    end
  end

  // Payload fields carry no reset; they are only read behind a busy state.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc_en && free_v[i] && free_idx == IW'(i)) begin
        line_q[i] <= alloc_line;
        id_q[i]   <= alloc_id;
        nc_q[i]   <= alloc_nc;
      end
    end
  end

endmodule

// File: rtl/mtrk_sec_table.sv
// Secondary table: repeat misses parked on a primary slot, with allocation age.
module mtrk_sec_table #(
  parameter int N      = 4,
  parameter int P      = 4,
  parameter int LINE_W = 28,
  parameter int ID_W   = 4,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int PIW = (P > 1) ? $clog2(P) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_en,
  input  logic [PIW-1:0]           alloc_parent,
  input  logic [ID_W-1:0]          alloc_id,
  input  logic [LINE_W-1:0]        alloc_line,
  input  logic                     free_en,
  input  logic [IW-1:0]            free_idx,
  input  logic [P-1:0]             parent_replay,
  output logic                     full,
  output logic                     busy_any,
  output logic [P-1:0]             child_any,
  output logic                     pick_any,
  output logic [IW-1:0]            pick_idx,
  output logic [N-1:0][LINE_W-1:0] ent_line,
  output logic [N-1:0][ID_W-1:0]   ent_id
);

  logic [N-1:0]        valid_q;
  logic [PIW-1:0]      par_q  [N];
  logic [ID_W-1:0]     id_q   [N];
  logic [LINE_W-1:0]   line_q [N];
  logic [N-1:0][N-1:0] older_q;

  logic [N-1:0]  cand;
  logic          slot_any;
  logic [IW-1:0] slot_idx;

  mtrk_first #(.N(N)) u_slot (.vec(~valid_q), .any(slot_any), .idx(slot_idx));

  assign full     = !slot_any;
  assign busy_any = |valid_q;

  always_comb begin
    child_any = '0;
    for (int i = 0; i < N; i++) begin
      cand[i]     = valid_q[i] && parent_replay[par_q[i]];
      ent_line[i] = line_q[i];
      ent_id[i]   = id_q[i];
      for (int p = 0; p < P; p++) begin
        if (valid_q[i] && par_q[i] == PIW'(p)) child_any[p] = 1'b1;
      end
    end
  end

  mtrk_oldest #(.N(N)) u_age (
    .cand (cand),
    .older(older_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (free_en && free_idx == IW'(i)) valid_q[i] <= 1'b0;
      end
      if (alloc_en && slot_any) begin
        valid_q[slot_idx] <= 1'b1;
        for (int j = 0; j < N; j++) begin
          older_q[slot_idx][j] <= 1'b0;
          older_q[j][slot_idx] <= valid_q[j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en && slot_any) begin
      par_q[slot_idx]  <= alloc_parent;
      id_q[slot_idx]   <= alloc_id;
      line_q[slot_idx] <= alloc_line;
    end
  end

endmodule

// File: rtl/miss_tracker.sv
// Top: lookup and stall decision, completion sequencing, drain status.
module miss_tracker #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 4,
  parameter int PRI_N  = 4,
  parameter int SEC_N  = 4,
  parameter int ID_W   = 4,
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int PIW    = (PRI_N > 1) ? $clog2(PRI_N) : 1,
  localparam int SIW    = (SEC_N > 1) ? $clog2(SEC_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_nc,
  input  logic [ID_W-1:0]   req_id,
  output logic              req_stall,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [LINE_W-1:0] bus_req_line,
  output logic [PIW-1:0]    bus_req_slot,
  output logic              bus_req_nc,
  input  logic              fill_valid,
  input  logic [PIW-1:0]    fill_slot,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [LINE_W-1:0] done_line,
  output logic              done_sec,
  input  logic              drain_req,
  output logic              drain_done
);

  logic [LINE_W-1:0] req_line;
  logic              unused_ofs;

  logic              hit_any, prim_free_any;
  logic [PIW-1:0]    hit_idx;
  logic              accept, prim_alloc, sec_alloc;

  logic [PRI_N-1:0]              p_filled, p_replay, p_busy, child_any;
  logic [PRI_N-1:0][LINE_W-1:0]  p_line;
  logic [PRI_N-1:0][ID_W-1:0]    p_id;

  logic                          sec_full, sec_busy, sec_pick_any;
  logic [SIW-1:0]                sec_pick_idx;
  logic [SEC_N-1:0][LINE_W-1:0]  s_line;
  logic [SEC_N-1:0][ID_W-1:0]    s_id;

  logic              fpick_any, sec_take;
  logic [PIW-1:0]    fpick_idx;

  logic              done_valid_q, done_sec_q;
  logic [ID_W-1:0]   done_id_q;
  logic [LINE_W-1:0] done_line_q;

  assign req_line   = req_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^req_addr[OFS_W-1:0];

  // Merge when a waiting line matches; otherwise need a free primary slot.
  always_comb begin
    req_stall = 1'b0;
    if (req_valid) begin
      if (drain_req)    req_stall = 1'b1;
      else if (hit_any) req_stall = sec_full;
      else              req_stall = !prim_free_any;
    end
  end

  assign accept     = req_valid && !req_stall;
  assign prim_alloc = accept && !hit_any;
  assign sec_alloc  = accept && hit_any;

  mtrk_prim_table #(.N(PRI_N), .LINE_W(LINE_W), .ID_W(ID_W)) u_prim (
    .clk        (clk),
    .rst        (rst),
    .lk_line    (req_line),
    .lk_nc      (req_nc),
    .lk_hit_any (hit_any),
    .lk_hit_idx (hit_idx),
    .free_any   (prim_free_any),
    .alloc_en   (prim_alloc),
    .alloc_line (req_line),
    .alloc_id   (req_id),
    .alloc_nc   (req_nc),
    .bus_valid  (bus_req_valid),
    .bus_ready  (bus_req_ready),
    .bus_slot   (bus_req_slot),
    .bus_line   (bus_req_line),
    .bus_nc     (bus_req_nc),
    .fill_valid (fill_valid),
    .fill_slot  (fill_slot),
    .cmp_take   (fpick_any),
    .cmp_slot   (fpick_idx),
    .child_any  (child_any),
    .filled_vec (p_filled),
    .replay_vec (p_replay),
    .busy_vec   (p_busy),
    .ent_line   (p_line),
    .ent_id     (p_id)
  );

  mtrk_sec_table #(.N(SEC_N), .P(PRI_N), .LINE_W(LINE_W), .ID_W(ID_W)) u_sec (
    .clk          (clk),
    .rst          (rst),
    .alloc_en     (sec_alloc),
    .alloc_parent (hit_idx),
    .alloc_id     (req_id),
    .alloc_line   (req_line),
    .free_en      (sec_take),
    .free_idx     (sec_pick_idx),
    .parent_replay(p_replay),
    .full         (sec_full),
    .busy_any     (sec_busy),
    .child_any    (child_any),
    .pick_any     (sec_pick_any),
    .pick_idx     (sec_pick_idx),
    .ent_line     (s_line),
    .ent_id       (s_id)
  );

  // Completion sequencer: owed primary completions first, then children.
  mtrk_first #(.N(PRI_N)) u_fpick (.vec(p_filled), .any(fpick_any), .idx(fpick_idx));

  assign sec_take = !fpick_any && sec_pick_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid_q <= 1'b0;
    end else begin
      done_valid_q <= fpick_any || sec_pick_any;
    end
  end

  always_ff @(posedge clk) begin
    if (fpick_any) begin
      done_id_q   <= p_id[fpick_idx];
      done_line_q <= p_line[fpick_idx];
      done_sec_q  <= 1'b0;
    end else begin
      done_id_q   <= s_id[sec_pick_idx];
      done_line_q <= s_line[sec_pick_idx];
      done_sec_q  <= 1'b1;
    end
  end

  assign done_valid = done_valid_q;
  assign done_id    = done_id_q;
  assign done_line  = done_line_q;
  assign done_sec   = done_sec_q;

  assign drain_done = drain_req && !(|p_busy) && !sec_busy;

endmodule

// File: rtl/miss_tracker_chk.sv
// Property checker, attached to every miss_tracker instance.
module miss_tracker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 4,
  parameter int PRI_N  = 4,
  parameter int SEC_N  = 4,
  parameter int ID_W   = 4,
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int PIW    = (PRI_N > 1) ? $clog2(PRI_N) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_nc,
  input logic [ID_W-1:0]   req_id,
  input logic              req_stall,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [LINE_W-1:0] bus_req_line,
  input logic [PIW-1:0]    bus_req_slot,
  input logic              bus_req_nc,
  input logic              fill_valid,
  input logic [PIW-1:0]    fill_slot,
  input logic              done_valid,
  input logic [ID_W-1:0]   done_id,
  input logic [LINE_W-1:0] done_line,
  input logic              done_sec,
  input logic              drain_req,
  input logic              drain_done
);

  // R1: an offer not taken stays put.
  a_r1_offer_held: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_req_ready |=>
      bus_req_valid && $stable(bus_req_slot) && $stable(bus_req_line) && $stable(bus_req_nc));

  // R5: no stall without a miss.
  a_r5_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !req_stall);

  // R9: drain holds off every miss.
  a_r9_drain_blocks: assert property (@(posedge clk) disable iff (rst)
    drain_req && req_valid |-> req_stall);

  // R9: empty tables mean nothing is offered.
  a_r9_empty_no_bus: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> !bus_req_valid);

  // R10: reset leaves no completion and no offer.
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done_valid && !bus_req_valid);

endmodule

bind miss_tracker miss_tracker_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PRI_N(PRI_N), .SEC_N(SEC_N), .ID_W(ID_W)
) u_chk (.*);

// File: tb/tb_miss_tracker.sv
module tb_miss_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 4;
  localparam int ID_W   = 4;
  localparam int LINE_W = ADDR_W - OFS_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_nc;
  logic [ID_W-1:0]   req_id;
  logic              req_stall;
  logic              bus_req_valid;
  logic              bus_req_ready;
  logic [LINE_W-1:0] bus_req_line;
  logic [1:0]        bus_req_slot;
  logic              bus_req_nc;
  logic              fill_valid;
  logic [1:0]        fill_slot;
  logic              done_valid;
  logic [ID_W-1:0]   done_id;
  logic [LINE_W-1:0] done_line;
  logic              done_sec;
  logic              drain_req;
  logic              drain_done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_tracker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_nc(req_nc), .req_id(req_id),
    .req_stall(req_stall),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_line(bus_req_line), .bus_req_slot(bus_req_slot), .bus_req_nc(bus_req_nc),
    .fill_valid(fill_valid), .fill_slot(fill_slot),
    .done_valid(done_valid), .done_id(done_id), .done_line(done_line), .done_sec(done_sec),
    .drain_req(drain_req), .drain_done(drain_done)
  );

  typedef struct packed {
    logic       rv;
    logic [7:0] ln;
    logic       nc;
    logic [3:0] id;
    logic       rdy;
    logic       fv;
    logic [1:0] fs;
    logic       dr;
    logic       e_stall;
    logic       e_bv;
    logic [1:0] e_bs;
    logic       e_dv;
    logic [3:0] e_did;
    logic       e_ds;
    logic       e_dd;
  } vec_t;

  function automatic vec_t mk(int rv, int ln, int nc, int id, int rdy, int fv, int fs,
                              int dr, int st, int bv, int bs, int dv, int did, int ds, int dd);
    vec_t v;
    v.rv = 1'(rv);  v.ln = 8'(ln);  v.nc = 1'(nc);  v.id = 4'(id);
    v.rdy = 1'(rdy); v.fv = 1'(fv); v.fs = 2'(fs);  v.dr = 1'(dr);
    v.e_stall = 1'(st); v.e_bv = 1'(bv); v.e_bs = 2'(bs);
    v.e_dv = 1'(dv); v.e_did = 4'(did); v.e_ds = 1'(ds); v.e_dd = 1'(dd);
    return v;
  endfunction

  // Inputs of a cycle, then the outputs expected just before its closing edge.
  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    //  rv ln nc id rdy fv fs dr | st bv bs dv did ds dd
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 0),  // idle
    mk(1, 1, 0, 1, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 0),  // new line 1 -> slot 0
    mk(1, 1, 0, 2, 0, 0, 0, 0,   0, 1, 0, 0, 0, 0, 0),  // merge
    mk(1, 1, 0, 3, 0, 0, 0, 0,   0, 1, 0, 0, 0, 0, 0),  // merge
    mk(1, 2, 0, 4, 0, 0, 0, 0,   0, 1, 0, 0, 0, 0, 0),  // new line 2 -> slot 1
    mk(0, 0, 0, 0, 1, 0, 0, 0,   0, 1, 0, 0, 0, 0, 0),  // bus takes slot 0
    mk(0, 0, 0, 0, 1, 0, 0, 0,   0, 1, 1, 0, 0, 0, 0),  // bus takes slot 1
    mk(0, 0, 0, 0, 0, 1, 0, 0,   0, 0, 0, 0, 0, 0, 0),  // fill slot 0
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 0),
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 1, 1, 0, 0),  // primary id 1
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 1, 2, 1, 0),  // child id 2
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 1, 3, 1, 0),  // child id 3
    mk(0, 0, 0, 0, 0, 0, 0, 1,   0, 0, 0, 0, 0, 0, 0),  // drain, slot 1 waits
    mk(1, 5, 0, 5, 0, 0, 0, 1,   1, 0, 0, 0, 0, 0, 0),  // miss stalled by drain
    mk(0, 0, 0, 0, 0, 1, 1, 1,   0, 0, 0, 0, 0, 0, 0),  // fill slot 1
    mk(0, 0, 0, 0, 0, 0, 0, 1,   0, 0, 0, 0, 0, 0, 0),
    mk(0, 0, 0, 0, 0, 0, 0, 1,   0, 0, 0, 1, 4, 0, 1),  // id 4, now empty
    mk(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, 0, 0, 0, 0)
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    req_valid = 1'b0; req_addr = '0; req_nc = 1'b0; req_id = '0;
    bus_req_ready = 1'b0; fill_valid = 1'b0; fill_slot = '0; drain_req = 1'b0;
  endtask

  task automatic miss(input int ln, input int id, input bit nc);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(ln) << OFS_W;
    req_id    = ID_W'(id);
    req_nc    = nc;
  endtask

  task automatic nxt();
    @(negedge clk);
    quiet();
  endtask

  task automatic do_reset();
    @(negedge clk);
    quiet();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    quiet();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    drain_req = 1'b1;
    #1;
    check("R10", "drain_done after reset", 32'(drain_done), 1);
    check("R10", "bus_req_valid after reset", 32'(bus_req_valid), 0);
    check("R10", "done_valid after reset", 32'(done_valid), 0);

    // Scripted sequence: R1 R2 R7 R9
    for (int k = 0; k < NVEC; k++) begin
      nxt();
      req_valid = VEC[k].rv;
      req_addr  = ADDR_W'(VEC[k].ln) << OFS_W;
      req_nc    = VEC[k].nc;
      req_id    = VEC[k].id;
      bus_req_ready = VEC[k].rdy;
      fill_valid    = VEC[k].fv;
      fill_slot     = VEC[k].fs;
      drain_req     = VEC[k].dr;
      #1;
      check("R9 R4 R3", $sformatf("vec%0d stall", k), 32'(req_stall), 32'(VEC[k].e_stall));
      check("R1 R2", $sformatf("vec%0d bus_valid", k), 32'(bus_req_valid), 32'(VEC[k].e_bv));
      if (VEC[k].e_bv)
        check("R1", $sformatf("vec%0d bus_slot", k), 32'(bus_req_slot), 32'(VEC[k].e_bs));
      check("R7", $sformatf("vec%0d done_valid", k), 32'(done_valid), 32'(VEC[k].e_dv));
      if (VEC[k].e_dv) begin
        check("R7", $sformatf("vec%0d done_id", k), 32'(done_id), 32'(VEC[k].e_did));
        check("R7", $sformatf("vec%0d done_sec", k), 32'(done_sec), 32'(VEC[k].e_ds));
      end
      check("R9", $sformatf("vec%0d drain_done", k), 32'(drain_done), 32'(VEC[k].e_dd));
    end

    // R10: reset with live entries empties everything
    nxt(); miss(10, 1, 0);
    nxt(); miss(11, 2, 0);
    do_reset();
    drain_req = 1'b1;
    #1;
    check("R10", "drain_done after reset with entries", 32'(drain_done), 1);
    check("R10", "no offer after reset", 32'(bus_req_valid), 0);

    // Full tables with the bus held off: R3 R4 R5 R8
    for (int i = 0; i < 4; i++) begin
      nxt(); miss(20 + i, i, 0);
      #1; check("R1", "fill primary stall", 32'(req_stall), 0);
    end
    nxt(); miss(24, 9, 0);
    #1; check("R3", "fifth distinct line stalls", 32'(req_stall), 1);
    nxt(); miss(20, 4, 0);
    #1; check("R5", "merge accepted while primary full", 32'(req_stall), 0);
    nxt();
    #1; check("R5", "no stall without a miss", 32'(req_stall), 0);
    check("R1", "oldest offer held on slot 0", 32'(bus_req_slot), 0);
    check("R1", "offered line", 32'(bus_req_line), 20);
    for (int i = 0; i < 3; i++) begin
      nxt(); miss(21, 5 + i, 0);
      #1; check("R2", "merge stall", 32'(req_stall), 0);
    end
    nxt(); miss(22, 8, 0);
    #1; check("R4", "merge with secondary full stalls", 32'(req_stall), 1);
    nxt(); fill_valid = 1'b1; fill_slot = 2'd2;
    for (int i = 0; i < 3; i++) begin
      nxt();
      #1; check("R8", "fill to unaccepted slot ignored", 32'(done_valid), 0);
    end
    check("R2", "merges raised no new offer", 32'(bus_req_slot), 0);

    // Uncached loads: R6
    do_reset();
    miss(30, 9, 1);
    #1; check("R6", "uncached accepted", 32'(req_stall), 0);
    nxt(); miss(30, 10, 0);
    #1; check("R6", "cacheable same line not merged", 32'(req_stall), 0);
    check("R6", "uncached offered", 32'(bus_req_nc), 1);
    nxt();
    #1; check("R6", "uncached still held", 32'(bus_req_valid), 1);
    check("R6", "no completion before accept", 32'(done_valid), 0);
    nxt(); bus_req_ready = 1'b1;
    #1; check("R6", "uncached slot", 32'(bus_req_slot), 0);
    nxt();
    #1; check("R6", "next offer is slot 1", 32'(bus_req_slot), 1);
    check("R6", "next offer cacheable", 32'(bus_req_nc), 0);
    check("R6", "next offer line", 32'(bus_req_line), 30);
    check("R6", "no done yet", 32'(done_valid), 0);
    nxt();
    #1; check("R6", "uncached done", 32'(done_valid), 1);
    check("R6", "uncached done id", 32'(done_id), 9);
    check("R6", "uncached done is primary", 32'(done_sec), 0);

    finish_run();
  end

endmodule